// File: doc/BRIEF.md
# Link equalization phase sequencer

This block steps one serial link through its transmitter equalization phases. It works for either port role. A downstream port runs phases 1 to 3, and an upstream port runs phases 0 to 3. The block gates each start request on the current and target data rates. For every transmitted training set it selects the set type (TS0 or TS1), the equalization-control (EC) value and the preset index. It moves to the next phase once enough consecutive received sets carry the expected EC value. A per-phase timeout abandons a stalled run.

Surrounding logic decodes received training sets into single-cycle events with their fields. It also pulses `tx_set_sent` each time a set leaves the transmitter. Serialization, line coding, coefficient search and filter computation are handled elsewhere.

Rate codes used on `cur_rate` and `tgt_rate`:

| Code | Rate |
|------|------|
| 0 | 2.5 GT/s |
| 1 | 5.0 GT/s |
| 2 | 8.0 GT/s |
| 3 | 16.0 GT/s |
| 4 | 32.0 GT/s |
| 5 | 64.0 GT/s |

Top module: `eq_phase_seq`

## Requirements
- R1: A synchronous reset (`rst`=1) clears `tx_sel_ts1`, `tx_ec`, `eq_done` and `eq_active` to 0 and clears the latched preset to 0.
- R2: When the target rate code is 2, 3 or 4, `tx_sel_ts1` is 1 in every phase for both roles.
- R3: For target code 5 with `role_dsp`=1, the select is TS0 (`tx_sel_ts1`=0) in phase 1. In phase 2 it is TS0 until SW_CNT (default 2) `tx_set_sent` pulses have been counted in that phase, and TS1 after that. Phase 3 is TS1.
- R4: For target code 5 with `role_dsp`=0, the select is TS0 in phases 0, 1 and 2. In phase 3 it is TS0 until SW_CNT `tx_set_sent` pulses have been counted, and TS1 after that.
- R5: An accepted start enters phase 1 if `role_dsp`=1 and phase 0 if `role_dsp`=0. `tx_preset` equals `cfg_preset` for the downstream role. For the upstream role it equals the value of `eq_ts2_preset` captured at the latest `eq_ts2_valid` pulse.
- R6: While TS0 is selected, `tx_ec` is 00b until two consecutive received TS0 sets (`rx_is_ts0`=1) arrive with `rx_ext`=0 within the current run. After that, `tx_ec` equals the phase number. A received TS0 with `rx_ext`=1 restarts that count. While TS1 is selected, `tx_ec` is the phase number. When idle, `tx_ec` is 00b.
- R7: A start is accepted only when all of these hold: `link_l0`=1, the target code is 2 to 5, and `cur_rate` is below the target. For target code 5, `cur_rate` must also be 4. A refused request raises `eq_reject` in the same cycle and the block stays idle.
- R8: An accepted `eq_req` with `skip_req`=1 and a target code below 5 runs no phases, and `eq_done` pulses on the next cycle. With target code 5, `skip_req` is ignored and the phases run.
- R9: `redo_req` starts a run under the same rate gating as `eq_req`, and `skip_req` never bypasses a redo.
- R10: The phase advances after ADV_CNT (default 2) consecutive received sets whose `rx_ec` equals the phase number (01b while in phase 0). A non-matching received set restarts the count. Completing phase 3 pulses `eq_done` for one cycle and returns to idle.
- R11: If TIMEOUT (default 64) cycles pass in one phase without an advance, `eq_fail` is 1 in the last of those cycles and the block is idle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| role_dsp | input | 1 | 1 = downstream role, 0 = upstream role |
| link_l0 | input | 1 | Link is in the active operating state |
| cur_rate | input | 3 | Current rate code |
| tgt_rate | input | 3 | Target rate code for the request |
| eq_req | input | 1 | Start-equalization request pulse |
| redo_req | input | 1 | Redo request pulse (problem flagged or peer asked) |
| skip_req | input | 1 | Ask to bypass equalization with `eq_req` |
| rx_set_valid | input | 1 | A received training set is decoded this cycle |
| rx_is_ts0 | input | 1 | The received set is TS0 |
| rx_ext | input | 1 | Retimer-extend bit of the received set |
| rx_ec | input | 2 | EC field of the received set |
| tx_set_sent | input | 1 | One training set left the transmitter |
| eq_ts2_valid | input | 1 | EQ TS2 preset capture strobe |
| eq_ts2_preset | input | PRESET_W | Preset carried by the EQ TS2 set |
| cfg_preset | input | PRESET_W | Configured preset for the downstream role |
| tx_sel_ts1 | output | 1 | Registered: 1 = send TS1, 0 = send TS0 |
| tx_ec | output | 2 | Registered EC value for transmitted sets |
| tx_preset | output | PRESET_W | Preset index for transmitted sets |
| eq_done | output | 1 | Registered one-cycle completion pulse |
| eq_active | output | 1 | A run is in progress |
| eq_phase | output | 2 | Current phase number |
| eq_reject | output | 1 | Request refused this cycle |
| eq_fail | output | 1 | Phase timeout this cycle |

## Verification
`eq_reject`, `eq_fail` and `tx_preset` depend combinationally on the inputs of the same cycle. The bench reads them about 10 ns after driving the stimulus, with no clock edge in between. `eq_active`, `eq_phase`, `tx_sel_ts1`, `tx_ec` and `eq_done` change on the first edge that samples the triggering event. Examples of such events are the accepted start, the ADV_CNT-th matching set, the second `tx_set_sent` pulse of a switching phase, and the second clean received TS0. The bench compares these outputs at the falling edge after that rising edge. The per-cycle reference model advances only on rising edges and is compared at every falling edge, so each result is checked in exactly the cycle it is due. The timeout is measured as TIMEOUT-1 rising edges from the entry edge to the cycle in which `eq_fail` appears.

// File: rtl/eq_seq_pkg.sv
package eq_seq_pkg;

    typedef enum logic [2:0] {
        RATE_2G5 = 3'd0,
        RATE_5G  = 3'd1,
        RATE_8G  = 3'd2,
        RATE_16G = 3'd3,
        RATE_32G = 3'd4,
        RATE_64G = 3'd5
    } rate_e;

    localparam int PHASE_W = 2;
    localparam logic [PHASE_W-1:0] LAST_PHASE = 2'd3;

endpackage

// File: rtl/eq_admit.sv
module eq_admit
    import eq_seq_pkg::*;
(
    input  logic [2:0] cur_rate,
    input  logic [2:0] tgt_rate,
    input  logic       link_l0,
    output logic       allowed
);

    always_comb begin
        allowed = 1'b0;
        if (link_l0 && (tgt_rate >= RATE_8G) && (tgt_rate <= RATE_64G)
            && (cur_rate < tgt_rate)) begin
            if (tgt_rate == RATE_64G) begin
                allowed = (cur_rate == RATE_32G);
            end else begin
                allowed = 1'b1;
            end
        end
    end

endmodule

// File: rtl/eq_set_select.sv
module eq_set_select
    import eq_seq_pkg::*;
(
    input  logic               active,
    input  logic               top_rate,
    input  logic               is_dsp,
    input  logic [PHASE_W-1:0] phase,
    input  logic               quota_met,
    output logic               send_ts1
);

    logic [PHASE_W-1:0] switch_phase;

    always_comb begin
        switch_phase = is_dsp ? 2'd2 : 2'd3;
        if (!active) begin
            send_ts1 = 1'b0;
        end else if (!top_rate) begin
            send_ts1 = 1'b1;
        end else if (phase < switch_phase) begin
            send_ts1 = 1'b0;
        end else if (phase == switch_phase) begin
            send_ts1 = quota_met;
        end else begin
            send_ts1 = 1'b1;
        end
    end

endmodule

// File: rtl/eq_ec_track.sv
module eq_ec_track #(
    parameter int NEED = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic rx_valid,
    input  logic rx_ts0,
    input  logic rx_ext,
    output logic ok_q,
    output logic ok_d
);

    localparam int CW = $clog2(NEED + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ok;
    } trk_t;

    trk_t t_q, t_d;

    always_comb begin
        t_d = t_q;
        if (clear) begin
            t_d = '0;
        end else if (rx_valid && rx_ts0) begin
            if (rx_ext) begin
                t_d.cnt = '0;
            end else if (t_q.cnt != CW'(NEED)) begin
                t_d.cnt = t_q.cnt + CW'(1);
            end
            if (t_d.cnt == CW'(NEED)) begin
                t_d.ok = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign ok_q = t_q.ok;
    assign ok_d = t_d.ok;

    // R6
    ec_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ok_q) |-> $past(rx_valid && rx_ts0 && !rx_ext));

endmodule

// File: rtl/eq_phase_seq.sv
module eq_phase_seq
    import eq_seq_pkg::*;
#(
    parameter int SW_CNT   = 2,
    parameter int ADV_CNT  = 2,
    parameter int TIMEOUT  = 64,
    parameter int PRESET_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                role_dsp,
    input  logic                link_l0,
    input  logic [2:0]          cur_rate,
    input  logic [2:0]          tgt_rate,
    input  logic                eq_req,
    input  logic                redo_req,
    input  logic                skip_req,
    input  logic                rx_set_valid,
    input  logic                rx_is_ts0,
    input  logic                rx_ext,
    input  logic [1:0]          rx_ec,
    input  logic                tx_set_sent,
    input  logic                eq_ts2_valid,
    input  logic [PRESET_W-1:0] eq_ts2_preset,
    input  logic [PRESET_W-1:0] cfg_preset,
    output logic                tx_sel_ts1,
    output logic [1:0]          tx_ec,
    output logic [PRESET_W-1:0] tx_preset,
    output logic                eq_done,
    output logic                eq_active,
    output logic [1:0]          eq_phase,
    output logic                eq_reject,
    output logic                eq_fail
);

    localparam int TXW = $clog2(SW_CNT + 1);
    localparam int RXW = $clog2(ADV_CNT + 1);
    localparam int TW  = $clog2(TIMEOUT + 1);
    localparam int EC_NEED = 2;

    typedef struct packed {
        logic                active;
        logic [PHASE_W-1:0]  phase;
        logic [TXW-1:0]      txc;
        logic [RXW-1:0]      rxc;
        logic [TW-1:0]       timer;
        logic                t64;
        logic [PRESET_W-1:0] preset;
    } core_t;

    typedef struct packed {
        logic       sel;
        logic [1:0] ec;
        logic       done;
    } out_t;

    core_t core_q, core_d;
    out_t  out_q, out_d;

    logic               allowed;
    logic               sel_d;
    logic               ec_ok_q;
    logic               ec_ok_d;
    logic               done_d;
    logic [PHASE_W-1:0] want_ec;
    logic               hit;

    eq_admit u_admit (
        .cur_rate (cur_rate),
        .tgt_rate (tgt_rate),
        .link_l0  (link_l0),
        .allowed  (allowed)
    );

    eq_ec_track #(.NEED(EC_NEED)) u_ec (
        .clk      (clk),
        .rst      (rst),
        .clear    (!core_q.active),
        .rx_valid (rx_set_valid),
        .rx_ts0   (rx_is_ts0),
        .rx_ext   (rx_ext),
        .ok_q     (ec_ok_q),
        .ok_d     (ec_ok_d)
    );

    // next core state
    always_comb begin
        core_d    = core_q;
        done_d    = 1'b0;
        eq_reject = 1'b0;
        eq_fail   = 1'b0;
        want_ec   = (core_q.phase == 2'd0) ? 2'd1 : core_q.phase;
        hit       = rx_set_valid && (rx_ec == want_ec);

        if (eq_ts2_valid) begin
            core_d.preset = eq_ts2_preset;
        end

        if (!core_q.active) begin
            if (eq_req || redo_req) begin
                if (!allowed) begin
                    eq_reject = 1'b1;
                end else if (eq_req && skip_req && (tgt_rate != RATE_64G)) begin
                    done_d = 1'b1;
                end else begin
                    core_d.active = 1'b1;
                    core_d.phase  = role_dsp ? 2'd1 : 2'd0;
                    core_d.txc    = '0;
                    core_d.rxc    = '0;
                    core_d.timer  = '0;
                    core_d.t64    = (tgt_rate == RATE_64G);
                end
            end
        end else begin
            if (tx_set_sent && (core_q.txc != TXW'(SW_CNT))) begin
                core_d.txc = core_q.txc + TXW'(1);
            end
            if (rx_set_valid) begin
                core_d.rxc = hit ? core_q.rxc + RXW'(1) : '0;
            end
            if (hit && (core_q.rxc == RXW'(ADV_CNT - 1))) begin
                if (core_q.phase == LAST_PHASE) begin
                    core_d.active = 1'b0;
                    done_d        = 1'b1;
                end else begin
                    core_d.phase = core_q.phase + 2'd1;
                    core_d.txc   = '0;
                    core_d.rxc   = '0;
                    core_d.timer = '0;
                end
            end else if (core_q.timer == TW'(TIMEOUT - 1)) begin
                eq_fail       = 1'b1;
                core_d.active = 1'b0;
            end else begin
                core_d.timer = core_q.timer + TW'(1);
            end
        end
    end

    eq_set_select u_sel (
        .active    (core_d.active),
        .top_rate  (core_d.t64),
        .is_dsp    (role_dsp),
        .phase     (core_d.phase),
        .quota_met (core_d.txc == TXW'(SW_CNT)),
        .send_ts1  (sel_d)
    );

    // next registered outputs
    always_comb begin
        out_d.sel  = sel_d;
        out_d.done = done_d;
        if (!core_d.active) begin
            out_d.ec = 2'd0;
        end else if (!sel_d && !ec_ok_d) begin
            out_d.ec = 2'd0;
        end else begin
            out_d.ec = core_d.phase;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q <= '0;
            out_q  <= '0;
        end else begin
            core_q <= core_d;
            out_q  <= out_d;
        end
    end

    assign tx_sel_ts1 = out_q.sel;
    assign tx_ec      = out_q.ec;
    assign eq_done    = out_q.done;
    assign eq_active  = core_q.active;
    assign eq_phase   = core_q.phase;
    assign tx_preset  = role_dsp ? cfg_preset : core_q.preset;

    // R7
    reject_idle_chk: assert property (@(posedge clk) disable iff (rst)
        eq_reject |=> !eq_active);

    // R5
    start_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(core_q.active) |-> (core_q.phase == ($past(role_dsp) ? 2'd1 : 2'd0)));

    // R2
    low_rate_ts1_chk: assert property (@(posedge clk) disable iff (rst)
        (core_q.active && !core_q.t64) |-> out_q.sel);

    // R10
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        (core_q.active && $past(core_q.active)) |->
            ((core_q.phase == $past(core_q.phase)) ||
             (core_q.phase == $past(core_q.phase) + 2'd1)));

    // R3
    ts1_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (core_q.active && $past(core_q.active) && $stable(core_q.phase))
            |-> !$fell(out_q.sel));

    // R11
    fail_exit_chk: assert property (@(posedge clk) disable iff (rst)
        eq_fail |=> (!eq_active && !eq_done));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        eq_done |-> !eq_active);

endmodule

// File: tb/sim_eq_phase_seq.sv
`timescale 1ns/1ps
module sim_eq_phase_seq;

    localparam int SW  = 2;
    localparam int ADV = 2;
    localparam int TO  = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       role_dsp = 1'b1, link_l0 = 1'b1;
    logic [2:0] cur_rate = 3'd4, tgt_rate = 3'd5;
    logic       eq_req = 0, redo_req = 0, skip_req = 0;
    logic       rx_set_valid = 0, rx_is_ts0 = 0, rx_ext = 0;
    logic [1:0] rx_ec = 0;
    logic       tx_set_sent = 0, eq_ts2_valid = 0;
    logic [3:0] eq_ts2_preset = 0, cfg_preset = 4'd5;
    logic       tx_sel_ts1, eq_done, eq_active, eq_reject, eq_fail;
    logic [1:0] tx_ec, eq_phase;
    logic [3:0] tx_preset;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    eq_phase_seq u0 (
        .clk(clk), .rst(rst), .role_dsp(role_dsp), .link_l0(link_l0),
        .cur_rate(cur_rate), .tgt_rate(tgt_rate), .eq_req(eq_req),
        .redo_req(redo_req), .skip_req(skip_req), .rx_set_valid(rx_set_valid),
        .rx_is_ts0(rx_is_ts0), .rx_ext(rx_ext), .rx_ec(rx_ec),
        .tx_set_sent(tx_set_sent), .eq_ts2_valid(eq_ts2_valid),
        .eq_ts2_preset(eq_ts2_preset), .cfg_preset(cfg_preset),
        .tx_sel_ts1(tx_sel_ts1), .tx_ec(tx_ec), .tx_preset(tx_preset),
        .eq_done(eq_done), .eq_active(eq_active), .eq_phase(eq_phase),
        .eq_reject(eq_reject), .eq_fail(eq_fail)
    );

    task automatic chk(input bit good, input string tag, input int act, input int exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int m_act, m_ph, m_tx, m_rx, m_tmr, m_t64, m_okc, m_ok, m_pre, m_sel, m_ec, m_done, m_dsp;

    function automatic int gate_ok();
        int c, t;
        c = int'(cur_rate);
        t = int'(tgt_rate);
        if (!link_l0) return 0;
        if (t < 2 || t > 5) return 0;
        if (c >= t) return 0;
        if (t == 5) return (c == 4) ? 1 : 0;
        return 1;
    endfunction

    function automatic int want_ec();
        return (m_ph == 0) ? 1 : m_ph;
    endfunction

    function automatic int hit_now();
        return (rx_set_valid && int'(rx_ec) == want_ec()) ? 1 : 0;
    endfunction

    function automatic int pick_ts1();
        int boundary;
        if (!m_act) return 0;
        if (!m_t64) return 1;
        boundary = role_dsp ? 2 : 3;
        if (m_ph > boundary) return 1;
        if (m_ph < boundary) return 0;
        return (m_tx >= SW) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_act = 0; m_ph = 0; m_tx = 0; m_rx = 0; m_tmr = 0; m_t64 = 0;
            m_okc = 0; m_ok = 0; m_pre = 0; m_sel = 0; m_ec = 0; m_done = 0;
        end else begin
            int h, prev_rx;
            h = hit_now();
            prev_rx = m_rx;
            m_done = 0;
            if (eq_ts2_valid) m_pre = int'(eq_ts2_preset);
            if (!m_act) begin
                m_okc = 0; m_ok = 0;
                if ((eq_req || redo_req) && gate_ok()) begin
                    if (eq_req && skip_req && tgt_rate != 3'd5) begin
                        m_done = 1;
                    end else begin
                        m_act = 1; m_ph = role_dsp ? 1 : 0;
                        m_tx = 0; m_rx = 0; m_tmr = 0;
                        m_t64 = (tgt_rate == 3'd5) ? 1 : 0;
                    end
                end
            end else begin
                if (rx_set_valid && rx_is_ts0) begin
                    if (rx_ext) m_okc = 0;
                    else if (m_okc < 2) m_okc++;
                    if (m_okc == 2) m_ok = 1;
                end
                if (tx_set_sent && m_tx < SW) m_tx++;
                if (rx_set_valid) m_rx = h ? m_rx + 1 : 0;
                if (h && prev_rx == ADV - 1) begin
                    if (m_ph == 3) begin
                        m_act = 0; m_done = 1;
                    end else begin
                        m_ph++; m_tx = 0; m_rx = 0; m_tmr = 0;
                    end
                end else if (m_tmr == TO - 1) begin
                    m_act = 0;
                end else begin
                    m_tmr++;
                end
            end
            m_sel = pick_ts1();
            if (!m_act) m_ec = 0;
            else if (!m_sel && !m_ok) m_ec = 0;
            else m_ec = m_ph;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            int e_rej, e_fail, e_pre;
            string stag;
            e_rej  = (!m_act && (eq_req || redo_req) && !gate_ok()) ? 1 : 0;
            e_fail = (!rst && m_act && m_tmr == TO - 1 && !(hit_now() && m_rx == ADV - 1)) ? 1 : 0;
            e_pre  = role_dsp ? int'(cfg_preset) : m_pre;
            stag   = !m_t64 ? "R2 set type" : (role_dsp ? "R3 set type" : "R4 set type");
            chk(int'(eq_active) == m_act, "R10 active", int'(eq_active), m_act);
            chk(!m_act || int'(eq_phase) == m_ph, "R10 phase", int'(eq_phase), m_ph);
            chk(int'(tx_sel_ts1) == m_sel, stag, int'(tx_sel_ts1), m_sel);
            chk(int'(tx_ec) == m_ec, "R6 ec", int'(tx_ec), m_ec);
            chk(int'(eq_done) == m_done, "R10 done", int'(eq_done), m_done);
            if (!rst) begin
                chk(int'(eq_reject) == e_rej, "R7 reject", int'(eq_reject), e_rej);
                chk(int'(eq_fail) == e_fail, "R11 fail", int'(eq_fail), e_fail);
                chk(int'(tx_preset) == e_pre, "R5 preset", int'(tx_preset), e_pre);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk);
        #1;
        eq_req = 0; redo_req = 0; skip_req = 0;
        rx_set_valid = 0; tx_set_sent = 0; eq_ts2_valid = 0;
    endtask

    task automatic rx(input int ec, input bit ts0, input bit ext);
        rx_set_valid = 1; rx_ec = 2'(ec); rx_is_ts0 = ts0; rx_ext = ext;
        step();
    endtask

    task automatic sent();
        tx_set_sent = 1;
        step();
    endtask

    task automatic run_to_fail(input string tag);
        int n = 0;
        while (!eq_fail && n < 200) begin
            step();
            n++;
        end
        chk(n == TO - 1, tag, n, TO - 1);
        step();
        chk(eq_active == 0, tag, int'(eq_active), 0);
    endtask

    task automatic try_reject(input int cur, input int tgt, input bit l0);
        cur_rate = 3'(cur); tgt_rate = 3'(tgt); link_l0 = l0;
        eq_req = 1;
        #2;
        chk(eq_reject == 1, "R7 refused request", int'(eq_reject), 1);
        step();
        chk(eq_active == 0, "R7 stays idle", int'(eq_active), 0);
        link_l0 = 1;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(tx_sel_ts1 == 0 && tx_ec == 0 && eq_done == 0 && eq_active == 0,
            "R1 reset state", int'({tx_sel_ts1, tx_ec, eq_done, eq_active}), 0);
        rst = 0;
        step();

        // downstream, 64 GT/s from 32 GT/s
        role_dsp = 1; cur_rate = 3'd4; tgt_rate = 3'd5;
        eq_req = 1;
        step();
        chk(eq_phase == 1, "R5 downstream start phase", int'(eq_phase), 1);
        chk(tx_sel_ts1 == 0, "R3 phase1 TS0", int'(tx_sel_ts1), 0);
        chk(tx_ec == 0, "R6 ec starts 00b", int'(tx_ec), 0);
        rx(0, 1, 0); rx(0, 1, 1); rx(0, 1, 0);
        chk(tx_ec == 0, "R6 extend bit restarts count", int'(tx_ec), 0);
        rx(0, 1, 0);
        chk(tx_ec == 1, "R6 ec unlocked", int'(tx_ec), 1);
        rx(1, 0, 0); rx(1, 0, 0);
        chk(eq_phase == 2, "R10 advance to 2", int'(eq_phase), 2);
        chk(tx_sel_ts1 == 0, "R3 phase2 starts TS0", int'(tx_sel_ts1), 0);
        sent();
        chk(tx_sel_ts1 == 0, "R3 one set sent", int'(tx_sel_ts1), 0);
        sent();
        chk(tx_sel_ts1 == 1, "R3 phase2 switches TS1", int'(tx_sel_ts1), 1);
        rx(2, 0, 0); rx(2, 0, 0);
        chk(eq_phase == 3 && tx_sel_ts1 == 1, "R3 phase3 TS1", int'(eq_phase), 3);
        rx(3, 0, 0); rx(2, 0, 0); rx(3, 0, 0);
        chk(eq_phase == 3 && eq_active == 1, "R10 mismatch restarts count", int'(eq_phase), 3);
        rx(3, 0, 0);
        chk(eq_done == 1 && eq_active == 0, "R10 done pulse", int'(eq_done), 1);
        step();
        chk(eq_done == 0, "R10 done one cycle", int'(eq_done), 0);

        // upstream with latched preset
        role_dsp = 0; eq_ts2_valid = 1; eq_ts2_preset = 4'd9;
        step();
        chk(tx_preset == 9, "R5 upstream preset latch", int'(tx_preset), 9);
        eq_req = 1;
        step();
        chk(eq_phase == 0 && eq_active == 1, "R5 upstream start phase", int'(eq_phase), 0);
        rx(1, 1, 0); rx(1, 1, 0);
        rx(1, 1, 0); rx(1, 1, 0);
        rx(2, 1, 0); rx(2, 1, 0);
        chk(eq_phase == 3 && tx_sel_ts1 == 0, "R4 phase3 starts TS0", int'(tx_sel_ts1), 0);
        sent(); sent();
        chk(tx_sel_ts1 == 1, "R4 phase3 switches TS1", int'(tx_sel_ts1), 1);
        rx(3, 0, 0); rx(3, 0, 0);
        chk(eq_done == 1, "R10 upstream done", int'(eq_done), 1);
        step();

        // low rate target: TS1 throughout, then timeout
        role_dsp = 1; cur_rate = 3'd2; tgt_rate = 3'd3; eq_req = 1;
        step();
        chk(tx_sel_ts1 == 1, "R2 low target TS1", int'(tx_sel_ts1), 1);
        run_to_fail("R11 timeout");

        // refusals
        try_reject(3, 5, 1);
        try_reject(5, 5, 1);
        try_reject(0, 5, 1);
        try_reject(4, 5, 0);
        try_reject(0, 1, 1);

        // skip honoured below 64, ignored at 64
        cur_rate = 3'd2; tgt_rate = 3'd3; eq_req = 1; skip_req = 1;
        step();
        chk(eq_done == 1 && eq_active == 0, "R8 skip bypass", int'(eq_done), 1);
        step();
        cur_rate = 3'd4; tgt_rate = 3'd5; eq_req = 1; skip_req = 1;
        step();
        chk(eq_active == 1, "R8 skip ignored at 64", int'(eq_active), 1);
        run_to_fail("R11 timeout after skip");

        // redo ignores skip
        cur_rate = 3'd2; tgt_rate = 3'd4; redo_req = 1; skip_req = 1;
        step();
        chk(eq_active == 1 && eq_done == 0, "R9 redo runs", int'(eq_active), 1);
        run_to_fail("R11 timeout after redo");

        // mixed stimulus against the model
        for (int seg = 0; seg < 6; seg++) begin
            role_dsp = seg[0];
            for (int i = 0; i < 500; i++) begin
                cur_rate = 3'($urandom_range(0, 5));
                tgt_rate = 3'($urandom_range(0, 5));
                link_l0 = ($urandom_range(0, 7) != 0);
                eq_req = ($urandom_range(0, 15) == 0);
                redo_req = ($urandom_range(0, 31) == 0);
                skip_req = ($urandom_range(0, 3) == 0);
                rx_set_valid = ($urandom_range(0, 1) == 1);
                rx_ec = 2'($urandom_range(0, 3));
                rx_is_ts0 = ($urandom_range(0, 1) == 1);
                rx_ext = ($urandom_range(0, 5) == 0);
                tx_set_sent = ($urandom_range(0, 2) == 0);
                eq_ts2_valid = ($urandom_range(0, 20) == 0);
                eq_ts2_preset = 4'($urandom_range(0, 10));
                step();
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule